// File: doc/BRIEF.md
# Edge Capture Transition Counter

This block is one timer channel that watches a single input pin. The pin is brought into the clock domain through a flop synchronizer, and its edges are qualified against a programmed edge mode. Every edge that qualifies adds one to a running transition count and stamps the value of one of two free-running timebases into a most-recent-edge register. When the count reaches a programmed limit, the same timebase value also goes into a completion register, and a latched interrupt flag is raised if interrupts are enabled.

Software sets the channel up through a small register-style write port. The control word holds the edge mode, the timebase choice, the run mode, the priority and the interrupt enable. A second word holds the count limit, and a third address clears the interrupt. The channel is then armed with an initialize service code.

There are two run modes. In single-shot mode the channel halts once the limit is reached. In continual mode it restarts the count and keeps going. The configuration port and the service input are control pins without flow control, and the results are plain register outputs.

Top module: `edge_xcount`

Control word fields (address 0):
- bits [2:0]: edge mode. 000 = none, 001 = rising, 010 = falling, 011 = both.
- bit 4: timebase choice. 0 = timebase 1, 1 = timebase 2.
- bit 7: run mode. 0 = single shot, 1 = continual.
- bits [9:8]: priority.
- bit 10: interrupt enable.

Address 1 holds the count limit. Address 2 clears the interrupt when bit 0 is written as 0.

## Requirements
- R1: After reset, count_o, last_ts_o, final_ts_o and irq_o are 0, and the channel is not armed.
- R2: Edge mode 001 counts only rising pin edges, 010 only falling edges, 011 both edges, and 000 no edges.
- R3: A control write whose bit 2 is 1 leaves the stored edge mode unchanged. The other fields in that same write still take effect.
- R4: Control bit 4 chooses the captured timebase: 0 takes tb1_i and 1 takes tb2_i.
- R5: Each counted edge adds 1 to count_o and loads last_ts_o with the chosen timebase value.
- R6: The counted edge that brings the count equal to the limit also loads final_ts_o with the same timebase value.
- R7: In single-shot mode (bit 7 = 0), the channel disarms on completion. Later edges leave count_o and both timestamps unchanged until the channel is armed again.
- R8: In continual mode (bit 7 = 1), count_o returns to 0 on completion, and the next counted edge gives 1.
- R9: Edges are counted only after svc_valid_i has been applied with svc_code_i = 01, and only while priority (bits [9:8]) is non-zero. A priority of 00 suspends counting. Other service codes are ignored. Arming clears count_o to 0.
- R10: irq_o is set on completion only when bit 10 is 1. It stays high until a write to address 2 with bit 0 = 0 clears it. A write there with bit 0 = 1 has no effect. If a set and a clear fall in the same cycle, the set wins.
- R11: A pin change applied before clock edge k becomes visible on the outputs after clock edge k+2.
- R12: A count limit of 0 never completes. The count simply keeps rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that also steps the timebases |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 1 | Watched input pin (asynchronous) |
| tb1_i | input | 16 | Timebase 1 |
| tb2_i | input | 16 | Timebase 2 |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Address: 0 = control, 1 = count limit, 2 = interrupt clear |
| cfg_wdata_i | input | 16 | Configuration write data |
| svc_valid_i | input | 1 | Service request strobe |
| svc_code_i | input | 2 | Service code; 01 arms the channel |
| count_o | output | 16 | Running transition count |
| last_ts_o | output | 16 | Timestamp of the most recent counted edge |
| final_ts_o | output | 16 | Timestamp of the edge that completed the count |
| irq_o | output | 1 | Latched interrupt flag |

## Verification
The assertions assume that reset is held over the first clock edges. They also assume that the count limit is not rewritten while the completing edge is in flight, so that completion and count stepping stay consistent.

The stimulus moves the pin only at falling clock edges. It holds both timebases steady from a pin change until the capture edge, and it changes them only between events, so every captured value can be predicted. Configuration writes, arming and interrupt clears are always placed between pin events, never in the same cycle as a capture.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  typedef enum logic [2:0] {
    EDGE_NONE = 3'b000,
    EDGE_RISE = 3'b001,
    EDGE_FALL = 3'b010,
    EDGE_BOTH = 3'b011
  } edge_mode_e;

  typedef struct packed {
    edge_mode_e mode;
    logic       tb_sel;
    logic       cont;
    logic [1:0] prio;
    logic       irq_en;
  } ecc_ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MAX  = 2'd1;
  localparam logic [1:0] ADDR_IRQ  = 2'd2;

  localparam int MODE_KEEP_BIT = 2;
  localparam int TB_SEL_BIT    = 4;
  localparam int CONT_BIT      = 7;
  localparam int PRIO_LSB      = 8;
  localparam int IEN_BIT       = 10;

  localparam logic [1:0] SVC_INIT = 2'b01;

endpackage

// File: rtl/ecc_edge.sv
module ecc_edge #(
  parameter int STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pin_i,
  input  ecc_pkg::edge_mode_e    mode_i,
  output logic                   hit_o
);
  import ecc_pkg::*;

  logic [STAGES-1:0] sr;
  logic              prev;
  logic              sync;
  logic              rise;
  logic              fall;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign sync = sr[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sync;
  end

  assign rise = sync & ~prev;
  assign fall = ~sync & prev;

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_BOTH: hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end

  // R2
  no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == EDGE_NONE) |-> !hit_o);

  // R2
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && mode_i == EDGE_RISE) |-> (sync && !prev));

endmodule

// File: rtl/ecc_cfg.sv
module ecc_cfg #(
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [DW-1:0]      wdata_i,
  output ecc_pkg::ecc_ctrl_t ctrl_o,
  output logic [DW-1:0]      max_o,
  output logic               irq_clr_o
);
  import ecc_pkg::*;

  logic ctrl_we;
  assign ctrl_we = we_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_o <= '0;
      max_o  <= '0;
    end else begin
      if (ctrl_we) begin
        if (!wdata_i[MODE_KEEP_BIT])
          ctrl_o.mode <= edge_mode_e'(wdata_i[2:0]);
        ctrl_o.tb_sel <= wdata_i[TB_SEL_BIT];
        ctrl_o.cont   <= wdata_i[CONT_BIT];
        ctrl_o.prio   <= wdata_i[PRIO_LSB +: 2];
        ctrl_o.irq_en <= wdata_i[IEN_BIT];
      end
      if (we_i && addr_i == ADDR_MAX)
        max_o <= wdata_i;
    end
  end

  assign irq_clr_o = we_i && (addr_i == ADDR_IRQ) && !wdata_i[0];

  // R3
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wdata_i[MODE_KEEP_BIT]) |=> $stable(ctrl_o.mode));

endmodule

// File: rtl/ecc_track.sv
module ecc_track #(
  parameter int DW   = 16,
  parameter int TS_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_i,
  input  logic               arm_i,
  input  ecc_pkg::ecc_ctrl_t ctrl_i,
  input  logic [DW-1:0]      max_i,
  input  logic               irq_clr_i,
  input  logic [TS_W-1:0]    tb1_i,
  input  logic [TS_W-1:0]    tb2_i,
  output logic [DW-1:0]      cnt_o,
  output logic [TS_W-1:0]    last_o,
  output logic [TS_W-1:0]    final_o,
  output logic               irq_o
);
  localparam logic [DW-1:0] ONE = 1;

  logic            armed;
  logic            cnt_en;
  logic            done;
  logic [DW-1:0]   nxt;
  logic [TS_W-1:0] ts;

  assign ts     = ctrl_i.tb_sel ? tb2_i : tb1_i;
  assign cnt_en = armed && (ctrl_i.prio != 2'b00) && hit_i && !arm_i;
  assign nxt    = cnt_o + ONE;
  assign done   = cnt_en && (nxt == max_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      cnt_o   <= '0;
      last_o  <= '0;
      final_o <= '0;
    end else if (arm_i) begin
      armed <= 1'b1;
      cnt_o <= '0;
    end else if (cnt_en) begin
      last_o <= ts;
      if (done) begin
        final_o <= ts;
        if (ctrl_i.cont) begin
          cnt_o <= '0;
        end else begin
          cnt_o <= nxt;
          armed <= 1'b0;
        end
      end else begin
        cnt_o <= nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     irq_o <= 1'b0;
    else if (done && ctrl_i.irq_en) irq_o <= 1'b1;
    else if (irq_clr_i)             irq_o <= 1'b0;
  end

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o != $past(cnt_o)) |-> ((cnt_o == $past(cnt_o) + ONE) || (cnt_o == '0)));

  // R6
  final_eq_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (final_o == last_o));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !arm_i) |=> ($stable(cnt_o) && $stable(last_o) && $stable(final_o)));

  // R9
  prio_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_i.prio == 2'b00) && !arm_i) |=> $stable(cnt_o));

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ctrl_i.irq_en) |=> irq_o);

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(done && ctrl_i.irq_en));

endmodule

// File: rtl/edge_xcount.sv
module edge_xcount #(
  parameter int DW          = 16,
  parameter int TS_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin_i,
  input  logic [TS_W-1:0] tb1_i,
  input  logic [TS_W-1:0] tb2_i,
  input  logic            cfg_we_i,
  input  logic [1:0]      cfg_addr_i,
  input  logic [DW-1:0]   cfg_wdata_i,
  input  logic            svc_valid_i,
  input  logic [1:0]      svc_code_i,
  output logic [DW-1:0]   count_o,
  output logic [TS_W-1:0] last_ts_o,
  output logic [TS_W-1:0] final_ts_o,
  output logic            irq_o
);
  import ecc_pkg::*;

  ecc_ctrl_t     ctrl;
  logic [DW-1:0] max_cnt;
  logic          irq_clr;
  logic          hit;
  logic          arm;

  assign arm = svc_valid_i && (svc_code_i == SVC_INIT);

  ecc_cfg #(.DW(DW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .ctrl_o    (ctrl),
    .max_o     (max_cnt),
    .irq_clr_o (irq_clr)
  );

  ecc_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .mode_i (ctrl.mode),
    .hit_o  (hit)
  );

  ecc_track #(.DW(DW), .TS_W(TS_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_i     (hit),
    .arm_i     (arm),
    .ctrl_i    (ctrl),
    .max_i     (max_cnt),
    .irq_clr_i (irq_clr),
    .tb1_i     (tb1_i),
    .tb2_i     (tb2_i),
    .cnt_o     (count_o),
    .last_o    (last_ts_o),
    .final_o   (final_ts_o),
    .irq_o     (irq_o)
  );

endmodule

// File: tb/edge_xcount_bench.sv
module edge_xcount_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [15:0] tb1 = '0, tb2 = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        svc_v = 1'b0;
  logic [1:0]  svc_c = '0;
  logic [15:0] cnt, last_ts, final_ts;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench model
  logic [2:0]  m_mode = 3'b000;
  logic        m_tsel = 0, m_cont = 0, m_ien = 0, m_armed = 0, m_irq = 0;
  logic [1:0]  m_prio = 0;
  logic [15:0] m_max = 0, m_cnt = 0, m_last = 0, m_final = 0;

  always #5 clk = ~clk;

  edge_xcount u_edge_xcount (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .tb1_i(tb1), .tb2_i(tb2),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .svc_valid_i(svc_v), .svc_code_i(svc_c),
    .count_o(cnt), .last_ts_o(last_ts), .final_ts_o(final_ts), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_ctrl(input logic [2:0] mode, input logic ts,
                                          input logic cont, input logic [1:0] prio,
                                          input logic ien);
    logic [15:0] w = '0;
    w[2:0] = mode; w[4] = ts; w[7] = cont; w[9:8] = prio; w[10] = ien;
    return w;
  endfunction

  function automatic bit qualifies(input logic [2:0] mode, input logic o, input logic n);
    case (mode)
      3'b001:  return !o && n;
      3'b010:  return o && !n;
      3'b011:  return o != n;
      default: return 0;
    endcase
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
    if (a == 2'd0) begin
      if (!d[2]) m_mode = d[2:0];
      m_tsel = d[4]; m_cont = d[7]; m_prio = d[9:8]; m_ien = d[10];
    end else if (a == 2'd1) m_max = d;
    else if (a == 2'd2 && !d[0]) m_irq = 0;
  endtask

  task automatic svc(input logic [1:0] code);
    @(negedge clk); svc_v = 1; svc_c = code;
    @(negedge clk); svc_v = 0;
    if (code == 2'b01) begin m_armed = 1; m_cnt = 0; end
  endtask

  task automatic check_all(input string req);
    chk({req, " count"}, cnt, m_cnt);
    chk({req, " last"}, last_ts, m_last);
    chk({req, " final"}, final_ts, m_final);
    chk({req, " irq"}, irq, m_irq);
  endtask

  // drive pin to level n; timebases held until capture, then checked
  task automatic edge_to(input logic n, input string req);
    logic [15:0] ts;
    @(negedge clk);
    tb1 = 16'($urandom); tb2 = 16'($urandom);
    ts = m_tsel ? tb2 : tb1;
    if (m_armed && m_prio != 0 && qualifies(m_mode, pin, n)) begin
      m_last = ts;
      if (m_cnt + 16'd1 == m_max) begin
        m_final = ts;
        if (m_ien) m_irq = 1;
        if (m_cont) m_cnt = 0;
        else begin m_cnt = m_cnt + 16'd1; m_armed = 0; end
      end else m_cnt = m_cnt + 16'd1;
    end
    pin = n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_all("R1");

    // R9: not armed, edges ignored
    wr(2'd1, 16'd3);
    wr(2'd0, mk_ctrl(3'b001, 0, 0, 2'd2, 1));
    edge_to(1, "R9 unarmed"); edge_to(0, "R9 unarmed");
    // R9: code 10 does not arm
    svc(2'b10);
    edge_to(1, "R9 code10"); edge_to(0, "R9 code10");
    chk("R9 code10 count", cnt, 16'd0);

    svc(2'b01);
    edge_to(1, "R5 rise1");
    chk("R5 count1", cnt, 16'd1);
    edge_to(0, "R2 fall ignored");
    chk("R2 fall ignored", cnt, 16'd1);
    edge_to(1, "R5 rise2");
    edge_to(0, "R2 fall");
    edge_to(1, "R6 complete");
    chk("R6 final=last", final_ts, last_ts);
    chk("R10 irq set", irq, 1'b1);
    edge_to(0, "R7"); edge_to(1, "R7 hold");
    chk("R7 count held", cnt, 16'd3);

    // R10 clear behaviour
    wr(2'd2, 16'h0001); @(negedge clk);
    chk("R10 write1 keeps irq", irq, 1'b1);
    wr(2'd2, 16'h0000); @(negedge clk);
    chk("R10 cleared", irq, 1'b0);

    // R3 keep mode (rising), R4 switch to tb2
    wr(2'd0, mk_ctrl(3'b110, 1, 0, 2'd1, 0));
    wr(2'd1, 16'd10);
    svc(2'b01);
    edge_to(0, "R3 fall not counted");
    chk("R3 mode kept", cnt, 16'd0);
    edge_to(1, "R4 tb2");
    chk("R4 last=tb2", last_ts, tb2);

    // R11 latency
    @(negedge clk); tb1 = 16'h1111; tb2 = 16'h2222; pin = 0;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R11 before", cnt, 16'd1);
    pin = 1; @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R11 not yet", cnt, 16'd1);
    @(posedge clk); @(negedge clk);
    chk("R11 visible", cnt, 16'd2);
    chk("R11 stamp", last_ts, 16'h2222);
    m_cnt = 2; m_last = 16'h2222; pin = 1;

    // R8 continual, both edges, interrupts disabled
    wr(2'd0, mk_ctrl(3'b011, 0, 1, 2'd3, 0));
    wr(2'd1, 16'd2);
    svc(2'b01);
    edge_to(0, "R8 c1"); chk("R8 c1", cnt, 16'd1);
    edge_to(1, "R8 wrap"); chk("R8 wrap to 0", cnt, 16'd0);
    chk("R10 no irq when disabled", irq, 1'b0);
    edge_to(0, "R8 restart"); chk("R8 restart 1", cnt, 16'd1);

    // R9 priority 0 suspends
    wr(2'd0, mk_ctrl(3'b011, 0, 1, 2'd0, 0));
    edge_to(1, "R9 prio0"); chk("R9 prio0 held", cnt, 16'd1);
    wr(2'd0, mk_ctrl(3'b011, 0, 1, 2'd1, 0));
    edge_to(0, "R9 resume");

    // R2 none mode
    wr(2'd0, mk_ctrl(3'b000, 0, 1, 2'd1, 0));
    edge_to(1, "R2 none"); edge_to(0, "R2 none");

    // R12 limit 0
    wr(2'd0, mk_ctrl(3'b011, 0, 0, 2'd1, 1));
    wr(2'd1, 16'd0);
    svc(2'b01);
    for (int i = 0; i < 4; i++) edge_to(~pin, "R12 no complete");
    chk("R12 count", cnt, 16'd4);
    chk("R12 irq", irq, 1'b0);

    // randomized mix
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 12) wr(2'd0, mk_ctrl(3'($urandom), 1'($urandom), 1'($urandom),
                                   2'($urandom_range(0, 3)), 1'($urandom)));
      else if (r < 18) wr(2'd1, 16'($urandom_range(0, 4)));
      else if (r < 24) svc(2'($urandom));
      else if (r < 28) wr(2'd2, 16'($urandom_range(0, 1)));
      else edge_to(~pin, "R5 random");
    end
    check_all("R6 random end");

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule